// File: doc/BRIEF.md
# Banked Shared RAM Arbiter

This block holds the program and data words of a small programmable timer engine and lets a host bus reach the same words. Storage is split into banks that each have their own read port and write port. Every cycle the timer engine may fetch its next instruction word through one read and store changed fields through one write. The host gets single-word reads and writes behind a valid/ready handshake.

The timer engine is never delayed, so its execution stays deterministic. A host access waits only in a cycle where it needs the same port of the same bank that the timer is using. Word addresses are interleaved over the banks, so a timer stepping through its program in a straight line moves away from the host's bank after one cycle. A timer that keeps using one bank locks the host out of that bank for as long as it does so. The block has no override that would let the host through.

Top module: `banked_ram_arbiter`

## Requirements
- R1: The low two address bits select the bank (4 banks) and the remaining upper bits select the word inside that bank. Addresses 1 and 5 share bank 1; address 6 is in bank 2.
- R2: A timer read issued in a cycle returns that word on the timer read data output in the next cycle. It is never stalled, and it returns the value from before any write made in the same cycle.
- R3: A timer write updates the addressed word at the clock edge of the cycle in which it is issued.
- R4: host_ready_o is high only while host_valid_i is high. It is low in any cycle where a host read targets the bank of an active timer read, or a host write targets the bank of an active timer write.
- R5: A valid host request that has no conflict as defined in R4 is granted in the same cycle, including while the timer uses other banks or uses the other port of the same bank.
- R6: A granted host read returns its word on host_rdata_o one cycle later, with host_rvalid_o high for exactly that cycle. host_rvalid_o is never high at any other time.
- R7: If the timer and the host write the same word in the same cycle, the timer value is stored and the host is stalled. The host write lands once it is granted in a later cycle.
- R8: A host read granted in the same cycle as a timer write to the same word returns the value from before the write.
- R9: While the timer reads the host's bank on every cycle, the host read is never granted. It is granted in the first cycle the timer stops using that bank.
- R10: After reset, host_rvalid_o is low, and host_ready_o is low while no request is valid.
- R11: A host write is stored once, and only in its granted cycle. Stalled cycles leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_rd_en_i | input | 1 | Timer instruction prefetch request |
| tmr_rd_addr_i | input | 6 | Timer prefetch word address |
| tmr_rd_data_o | output | 96 | Timer prefetch data, one cycle after request |
| tmr_wr_en_i | input | 1 | Timer write-back request |
| tmr_wr_addr_i | input | 6 | Timer write-back word address |
| tmr_wr_data_i | input | 96 | Timer write-back data |
| host_valid_i | input | 1 | Host request valid |
| host_we_i | input | 1 | Host request is a write |
| host_addr_i | input | 6 | Host word address |
| host_wdata_i | input | 96 | Host write data |
| host_ready_o | output | 1 | Host request granted this cycle |
| host_rdata_o | output | 96 | Host read data |
| host_rvalid_o | output | 1 | Host read data valid |

## Verification
A linear timer prefetch sweep runs alongside host reads. It shows whether bank interleaving lets the host through within a cycle. Fully random timer and host traffic, with each host request held until it is granted, is followed by a host readback of every word. That readback separates lost or repeated host writes from correct ones. Directed cases cover the rest: a same-bank pair against a different-bank pair, a same-word double write, and a host read racing a timer write. These tell wrong bank decode, wrong write priority and wrong read-before-write ordering apart. A long run of timer reads to one bank shows that the host is starved and then released on the first free cycle.

// File: rtl/ram_arb_pkg.sv
package ram_arb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_HOST  = 2'd2
  } port_src_e;
endpackage

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int WORD_W = 96,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  // read-before-write on a same-word collision
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= mem_q[rd_idx_i];
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end
endmodule

// File: rtl/bank_port_arb.sv
module bank_port_arb #(
  parameter int WORD_W  = 96,
  parameter int BANK_W  = 2,
  parameter int IDX_W   = 4,
  parameter int BANK_ID = 0
) (
  input  logic              t_rd_en_i,
  input  logic [BANK_W-1:0] t_rd_bank_i,
  input  logic [IDX_W-1:0]  t_rd_idx_i,
  input  logic              t_wr_en_i,
  input  logic [BANK_W-1:0] t_wr_bank_i,
  input  logic [IDX_W-1:0]  t_wr_idx_i,
  input  logic [WORD_W-1:0] t_wr_data_i,
  input  logic              h_valid_i,
  input  logic              h_we_i,
  input  logic [BANK_W-1:0] h_bank_i,
  input  logic [IDX_W-1:0]  h_idx_i,
  input  logic [WORD_W-1:0] h_wdata_i,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  output ram_arb_pkg::port_src_e rd_src_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              conflict_o
);
  import ram_arb_pkg::*;

  logic t_rd_hit, t_wr_hit, h_rd_hit, h_wr_hit;

  always_comb begin
    t_rd_hit = t_rd_en_i && (t_rd_bank_i == BANK_W'(BANK_ID));
    t_wr_hit = t_wr_en_i && (t_wr_bank_i == BANK_W'(BANK_ID));
    h_rd_hit = h_valid_i && !h_we_i && (h_bank_i == BANK_W'(BANK_ID));
    h_wr_hit = h_valid_i &&  h_we_i && (h_bank_i == BANK_W'(BANK_ID));

    conflict_o = (t_rd_hit && h_rd_hit) || (t_wr_hit && h_wr_hit);

    rd_en_o  = t_rd_hit || h_rd_hit;
    rd_idx_o = t_rd_hit ? t_rd_idx_i : h_idx_i;
    if (t_rd_hit)      rd_src_o = SRC_TIMER;
    else if (h_rd_hit) rd_src_o = SRC_HOST;
    else               rd_src_o = SRC_NONE;

    wr_en_o   = t_wr_hit || h_wr_hit;
    wr_idx_o  = t_wr_hit ? t_wr_idx_i  : h_idx_i;
    wr_data_o = t_wr_hit ? t_wr_data_i : h_wdata_i;
  end
endmodule

// File: rtl/read_return.sv
module read_return #(
  parameter int NUM_BANKS = 4,
  parameter int WORD_W    = 96,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              t_rd_en_i,
  input  logic [BANK_W-1:0] t_rd_bank_i,
  input  logic              h_rd_grant_i,
  input  logic [BANK_W-1:0] h_bank_i,
  input  logic [WORD_W-1:0] bank_rdata_i [NUM_BANKS],
  output logic [WORD_W-1:0] t_rdata_o,
  output logic [WORD_W-1:0] h_rdata_o,
  output logic              h_rvalid_o
);
  logic [BANK_W-1:0] t_bank_q, h_bank_q;
  logic              t_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_bank_q   <= '0;
      h_bank_q   <= '0;
      t_pend_q   <= 1'b0;
      h_rvalid_o <= 1'b0;
    end else begin
      t_pend_q   <= t_rd_en_i;
      h_rvalid_o <= h_rd_grant_i;
      if (t_rd_en_i)    t_bank_q <= t_rd_bank_i;
      if (h_rd_grant_i) h_bank_q <= h_bank_i;
    end
  end

  assign t_rdata_o = t_pend_q   ? bank_rdata_i[t_bank_q] : '0;
  assign h_rdata_o = h_rvalid_o ? bank_rdata_i[h_bank_q] : '0;
endmodule

// File: rtl/banked_ram_arbiter.sv
module banked_ram_arbiter #(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_DEPTH = 16,
  parameter int WORD_W     = 96,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int IDX_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = BANK_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_rd_en_i,
  input  logic [ADDR_W-1:0] tmr_rd_addr_i,
  output logic [WORD_W-1:0] tmr_rd_data_o,
  input  logic              tmr_wr_en_i,
  input  logic [ADDR_W-1:0] tmr_wr_addr_i,
  input  logic [WORD_W-1:0] tmr_wr_data_i,
  input  logic              host_valid_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic              host_ready_o,
  output logic [WORD_W-1:0] host_rdata_o,
  output logic              host_rvalid_o
);
  import ram_arb_pkg::*;

  // interleaved map: low bits pick the bank
  logic [BANK_W-1:0] t_rd_bank, t_wr_bank, h_bank;
  logic [IDX_W-1:0]  t_rd_idx,  t_wr_idx,  h_idx;

  assign t_rd_bank = tmr_rd_addr_i[BANK_W-1:0];
  assign t_rd_idx  = tmr_rd_addr_i[ADDR_W-1:BANK_W];
  assign t_wr_bank = tmr_wr_addr_i[BANK_W-1:0];
  assign t_wr_idx  = tmr_wr_addr_i[ADDR_W-1:BANK_W];
  assign h_bank    = host_addr_i[BANK_W-1:0];
  assign h_idx     = host_addr_i[ADDR_W-1:BANK_W];

  logic [NUM_BANKS-1:0] conflict;
  logic [NUM_BANKS-1:0] rd_en, wr_en, wr_en_gated;
  logic [IDX_W-1:0]     rd_idx [NUM_BANKS];
  logic [IDX_W-1:0]     wr_idx [NUM_BANKS];
  logic [WORD_W-1:0]    wr_data [NUM_BANKS];
  logic [WORD_W-1:0]    bank_rdata [NUM_BANKS];
  port_src_e            rd_src [NUM_BANKS];
  logic                 host_stall;

  assign host_stall   = |conflict;
  assign host_ready_o = host_valid_i && !host_stall;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_port_arb #(
      .WORD_W (WORD_W),
      .BANK_W (BANK_W),
      .IDX_W  (IDX_W),
      .BANK_ID(b)
    ) u_arb (
      .t_rd_en_i  (tmr_rd_en_i),
      .t_rd_bank_i(t_rd_bank),
      .t_rd_idx_i (t_rd_idx),
      .t_wr_en_i  (tmr_wr_en_i),
      .t_wr_bank_i(t_wr_bank),
      .t_wr_idx_i (t_wr_idx),
      .t_wr_data_i(tmr_wr_data_i),
      .h_valid_i  (host_valid_i),
      .h_we_i     (host_we_i),
      .h_bank_i   (h_bank),
      .h_idx_i    (h_idx),
      .h_wdata_i  (host_wdata_i),
      .rd_en_o    (rd_en[b]),
      .rd_idx_o   (rd_idx[b]),
      .rd_src_o   (rd_src[b]),
      .wr_en_o    (wr_en[b]),
      .wr_idx_o   (wr_idx[b]),
      .wr_data_o  (wr_data[b]),
      .conflict_o (conflict[b])
    );

    // a host write that lost its port must not reach the array
    assign wr_en_gated[b] = wr_en[b] &&
                            !(conflict[b] && !(tmr_wr_en_i && t_wr_bank == BANK_W'(b)));

    bank_ram #(
      .WORD_W(WORD_W),
      .DEPTH (BANK_DEPTH)
    ) u_ram (
      .clk_i    (clk_i),
      .rd_en_i  (rd_en[b]),
      .rd_idx_i (rd_idx[b]),
      .rd_data_o(bank_rdata[b]),
      .wr_en_i  (wr_en_gated[b]),
      .wr_idx_i (wr_idx[b]),
      .wr_data_i(wr_data[b])
    );
  end

  logic h_rd_grant;
  assign h_rd_grant = host_ready_o && !host_we_i && (rd_src[h_bank] == SRC_HOST);

  read_return #(
    .NUM_BANKS(NUM_BANKS),
    .WORD_W   (WORD_W)
  ) u_ret (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .t_rd_en_i   (tmr_rd_en_i),
    .t_rd_bank_i (t_rd_bank),
    .h_rd_grant_i(h_rd_grant),
    .h_bank_i    (h_bank),
    .bank_rdata_i(bank_rdata),
    .t_rdata_o   (tmr_rd_data_o),
    .h_rdata_o   (host_rdata_o),
    .h_rvalid_o  (host_rvalid_o)
  );
endmodule

// File: rtl/banked_ram_arbiter_chk.sv
module banked_ram_arbiter_chk #(
  parameter int ADDR_W = 6,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tmr_rd_en_i,
  input logic [ADDR_W-1:0] tmr_rd_addr_i,
  input logic              tmr_wr_en_i,
  input logic [ADDR_W-1:0] tmr_wr_addr_i,
  input logic              host_valid_i,
  input logic              host_we_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic              host_ready_o,
  input logic              host_rvalid_o
);
  logic rd_clash, wr_clash;
  assign rd_clash = host_valid_i && !host_we_i && tmr_rd_en_i &&
                    (host_addr_i[BANK_W-1:0] == tmr_rd_addr_i[BANK_W-1:0]);
  assign wr_clash = host_valid_i && host_we_i && tmr_wr_en_i &&
                    (host_addr_i[BANK_W-1:0] == tmr_wr_addr_i[BANK_W-1:0]);

  AST_READY_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> host_valid_i); // R4
  AST_RD_CLASH_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clash |-> !host_ready_o); // R4
  AST_WR_CLASH_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clash |-> !host_ready_o); // R7
  AST_FREE_BANK_GRANTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_i && !rd_clash && !wr_clash) |-> host_ready_o); // R5
  AST_RVALID_AFTER_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_valid_i && host_ready_o && !host_we_i) |=> host_rvalid_o); // R6
  AST_NO_STRAY_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> $past(host_valid_i && host_ready_o && !host_we_i)); // R6
endmodule

bind banked_ram_arbiter banked_ram_arbiter_chk #(
  .ADDR_W(ADDR_W),
  .BANK_W(BANK_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tmr_rd_en_i  (tmr_rd_en_i),
  .tmr_rd_addr_i(tmr_rd_addr_i),
  .tmr_wr_en_i  (tmr_wr_en_i),
  .tmr_wr_addr_i(tmr_wr_addr_i),
  .host_valid_i (host_valid_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_ready_o (host_ready_o),
  .host_rvalid_o(host_rvalid_o)
);

// File: tb/tb_banked_ram_arbiter.sv
module tb_banked_ram_arbiter;
  localparam int AW = 6;
  localparam int DW = 96;
  localparam int NW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trd_en = 0, twr_en = 0, hv = 0, hwe = 0;
  logic [AW-1:0] trd_addr = '0, twr_addr = '0, haddr = '0;
  logic [DW-1:0] twr_data = '0, hwdata = '0;
  logic [DW-1:0] trd_data, hrdata;
  logic          hready, hrvalid;

  always #10 clk = ~clk;

  banked_ram_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .tmr_rd_en_i(trd_en), .tmr_rd_addr_i(trd_addr), .tmr_rd_data_o(trd_data),
    .tmr_wr_en_i(twr_en), .tmr_wr_addr_i(twr_addr), .tmr_wr_data_i(twr_data),
    .host_valid_i(hv), .host_we_i(hwe), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .host_ready_o(hready), .host_rdata_o(hrdata), .host_rvalid_o(hrvalid)
  );

  logic [DW-1:0] mdl [NW];
  int  checks = 0, fails = 0;
  bit  done = 0;
  bit  last_grant;
  logic [DW-1:0] last_hrdata;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rnd96();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  // one clock of the reference model; inputs already set after a falling edge
  task automatic tick();
    bit exp_rdy, rd_clash, wr_clash, exp_hrd, exp_trd;
    logic [DW-1:0] exp_tdata, exp_hdata;
    #1;
    rd_clash = hv && !hwe && trd_en && (haddr % 4 == trd_addr % 4);
    wr_clash = hv &&  hwe && twr_en && (haddr % 4 == twr_addr % 4);
    exp_rdy  = hv && !rd_clash && !wr_clash;
    chk(hready === exp_rdy, (rd_clash || wr_clash || !hv) ? "R4" : "R5",
        DW'(hready), DW'(exp_rdy));
    exp_trd   = trd_en;
    exp_tdata = mdl[trd_addr];
    exp_hrd   = exp_rdy && !hwe;
    exp_hdata = mdl[haddr];
    @(posedge clk);
    if (twr_en) mdl[twr_addr] = twr_data;
    if (exp_rdy && hwe) mdl[haddr] = hwdata;
    last_grant = exp_rdy;
    @(negedge clk);
    if (exp_trd) chk(trd_data === exp_tdata, "R2", trd_data, exp_tdata);
    chk(hrvalid === exp_hrd, "R6", DW'(hrvalid), DW'(exp_hrd));
    if (exp_hrd) chk(hrdata === exp_hdata, "R6", hrdata, exp_hdata);
    last_hrdata = hrdata;
  endtask

  task automatic idle();
    trd_en = 0; twr_en = 0; hv = 0; hwe = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(hrvalid === 1'b0, "R10", DW'(hrvalid), '0);
    chk(hready === 1'b0, "R10", DW'(hready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hrvalid === 1'b0, "R10", DW'(hrvalid), '0);

    // fill every word through the timer write port (R3)
    for (int a = 0; a < NW; a++) begin
      idle(); twr_en = 1; twr_addr = AW'(a); twr_data = rnd96();
      tick();
    end
    idle();

    // linear prefetch sweep with host reads (R2, R5)
    for (int i = 0; i < 200; i++) begin
      trd_en = 1; trd_addr = AW'(i);
      if (!hv) begin hv = 1; hwe = 0; haddr = AW'($urandom_range(0, NW-1)); end
      tick();
      if (last_grant) hv = 0;
    end
    idle();

    // random traffic, host request held until granted (R3, R4, R11)
    for (int i = 0; i < 3000; i++) begin
      trd_en = 1'($urandom()); trd_addr = AW'($urandom());
      twr_en = 1'($urandom()); twr_addr = AW'($urandom()); twr_data = rnd96();
      if (!hv && ($urandom_range(0, 3) != 0)) begin
        hv = 1; hwe = 1'($urandom()); haddr = AW'($urandom()); hwdata = rnd96();
      end
      tick();
      if (last_grant) hv = 0;
    end
    idle();
    tick();
    // host readback of all words, timer idle (R11)
    for (int a = 0; a < NW; a++) begin
      idle(); hv = 1; hwe = 0; haddr = AW'(a);
      tick();
      chk(last_grant == 1'b1, "R11", DW'(last_grant), 1);
    end
    idle();

    // bank decode (R1)
    trd_en = 1; trd_addr = 6'd1; hv = 1; hwe = 0; haddr = 6'd5;
    tick();
    chk(last_grant == 1'b0, "R1", DW'(last_grant), 0);
    haddr = 6'd6;
    tick();
    chk(last_grant == 1'b1, "R1", DW'(last_grant), 1);
    idle();

    // same-word double write: timer wins, host lands later (R7)
    begin
      logic [DW-1:0] tv, hvv;
      tv = rnd96(); hvv = rnd96();
      twr_en = 1; twr_addr = 6'd9; twr_data = tv;
      hv = 1; hwe = 1; haddr = 6'd9; hwdata = hvv;
      tick();
      chk(last_grant == 1'b0, "R7", DW'(last_grant), 0);
      twr_en = 0; trd_en = 1; trd_addr = 6'd9;
      tick();
      chk(last_grant == 1'b1, "R7", DW'(last_grant), 1);
      chk(trd_data === tv, "R7", trd_data, tv);
      idle(); hv = 1; hwe = 0; haddr = 6'd9;
      tick();
      chk(last_hrdata === hvv, "R7", last_hrdata, hvv);
      idle();
    end

    // host read racing a timer write to the same word (R8)
    begin
      logic [DW-1:0] oldv, newv;
      oldv = mdl[10]; newv = ~oldv;
      twr_en = 1; twr_addr = 6'd10; twr_data = newv;
      hv = 1; hwe = 0; haddr = 6'd10;
      tick();
      chk(last_grant == 1'b1, "R8", DW'(last_grant), 1);
      chk(last_hrdata === oldv, "R8", last_hrdata, oldv);
      idle();
    end

    // sustained timer reads on bank 2 starve the host (R9)
    begin
      int grants = 0;
      hv = 1; hwe = 0; haddr = 6'd6;
      for (int i = 0; i < 60; i++) begin
        trd_en = 1; trd_addr = AW'(2 + 4 * (i % 16));
        tick();
        if (last_grant) grants++;
      end
      chk(grants == 0, "R9", DW'(grants), 0);
      trd_en = 1; trd_addr = 6'd3;
      tick();
      chk(last_grant == 1'b1, "R9", DW'(last_grant), 1);
      idle();
      tick();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired t=%0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule